// File: doc/BRIEF.md
# Power Mode Transition Sequencer

This block steers a processor between three power modes: run (normal operation), idle (CPU clock stopped, I/O logic still powered) and sleep (nearly everything off, only wakeup detection alive). Idle is entered and left quickly, and only the CPU clock is gated. Sleep is entered and left through fixed multi-step sequences. Each step holds its output for a set number of ticks of an external time base.

States and transitions. RUN goes to RUN_TO_IDLE on an idle request. RUN_TO_IDLE goes to IDLE when its timer ends. IDLE goes to IDLE_TO_RUN on a wakeup event or a sleep request. IDLE_TO_RUN goes to RUN when its timer ends. RUN goes to FLUSH on a sleep request, or on a sleep request remembered from IDLE. The sleep entry then runs FLUSH, then RESET (processor reset and wakeup armed), then CLKOFF, then SLEEP, each step ending when its timer ends. SLEEP goes to RAMP on a wakeup event, or on one latched during the entry. The sleep exit then runs RAMP, then STABILIZE, each ending when its timer ends, then BOOT. BOOT lasts one clock and returns to RUN.

The default durations assume one tick every 10 µs. Idle entry and exit take 1 tick each. Flush, reset and clock-off take 3 ticks each, about 90 µs together. The supply ramp takes 1000 ticks and clock stabilization 15000 ticks, about 160 ms together. Booting takes no ticks.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in RUN. The outputs are cpu_clk_en=1, io_pwr_keep=1 and status=3'b000, and flush_req, cpu_rst, clkgen_off, supply_ramp_en and boot_pulse are all 0.
- R2: In RUN, an idle request passes through RUN_TO_IDLE for exactly TICKS_TO_IDLE ticks with cpu_clk_en=0, then enters IDLE.
- R3: In IDLE, a wakeup event passes through IDLE_TO_RUN for exactly TICKS_FROM_IDLE ticks with cpu_clk_en=0, then enters RUN.
- R4: A sleep request in RUN runs FLUSH (flush_req=1) for TICKS_FLUSH ticks. It then runs RESET (cpu_rst=1, clkgen_off=0) for TICKS_RESET ticks, then CLKOFF (cpu_rst=1, clkgen_off=1) for TICKS_CLKOFF ticks, then enters SLEEP.
- R5: In SLEEP, cpu_clk_en=0, io_pwr_keep=0, supply_ramp_en=0 and clkgen_off=1.
- R6: A wakeup event in SLEEP runs RAMP (supply_ramp_en=1) for TICKS_RAMP ticks, then STABILIZE (cpu_rst=1, clkgen_off=0) for TICKS_STAB ticks. It then runs BOOT, where boot_pulse=1 for exactly one clock, and then enters RUN.
- R7: A wakeup event during FLUSH, RESET or CLKOFF is latched. Every entry step still runs its full duration. SLEEP then lasts one clock before RAMP starts, with no further wakeup needed.
- R8: A sleep request in IDLE runs IDLE_TO_RUN, then one clock of RUN, and only then FLUSH.
- R9: In RUN, a sleep request takes priority over an idle request that arrives in the same clock.
- R10: status[1:0] gives the mode (00 run, 01 idle, 10 sleep) and status[2] is 1 during a transition. RUN_TO_IDLE reports idle. FLUSH, RESET and CLKOFF report sleep. IDLE_TO_RUN, RAMP, STABILIZE and BOOT report run.
- R11: Idle and sleep requests have no effect in SLEEP, and a wakeup event has no effect in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe of the time base |
| idle_req | input | 1 | Request to enter idle |
| sleep_req | input | 1 | Request to enter sleep |
| wake_evt | input | 1 | Wakeup event |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_pwr_keep | output | 1 | Keep I/O logic powered |
| flush_req | output | 1 | Request to save CPU state to memory |
| cpu_rst | output | 1 | Processor reset |
| clkgen_off | output | 1 | Clock generator shutdown |
| supply_ramp_en | output | 1 | Main supply ramp enable |
| boot_pulse | output | 1 | One-clock boot start |
| status | output | 3 | {busy, mode[1:0]} |

## Verification
The assertions assume three things about the inputs. Every duration parameter is at least 1. tick is a single-clock strobe. A latched event keeps its effect even after the input has dropped. The stimulus drives requests and wakeup events as one-clock pulses on the falling edge. It sweeps the tick spacing from one to four clocks, so every step boundary falls both on back-to-back ticks and on sparse ticks. Step durations are measured by counting ticks while each externally visible phase lasts, and these counts are compared with the bench's own parameters.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [3:0] {
        ST_RUN, ST_R2I, ST_IDLE, ST_I2R,
        ST_FLUSH, ST_RESET, ST_CLKOFF, ST_SLEEP,
        ST_RAMP, ST_STAB, ST_BOOT
    } pms_state_e;

    localparam logic [1:0] MODE_RUN   = 2'd0;
    localparam logic [1:0] MODE_IDLE  = 2'd1;
    localparam logic [1:0] MODE_SLEEP = 2'd2;

    function automatic int pms_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pms_step_timer.sv
module pms_step_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] dur,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == dur - CW'(1));
    assign done   = tick && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (restart)         cnt <= '0;
        else if (tick && !at_end) cnt <= cnt + CW'(1);
    end

    // R4/R6: a step count never passes its own duration
    p_cnt_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < dur);
endmodule

// File: rtl/pms_event_latch.sv
module pms_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend <= 1'b0;
        else if (clr) pend <= 1'b0;
        else if (set) pend <= 1'b1;
    end

    // R7: serving the event always empties the latch
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int TICKS_TO_IDLE   = 1,
    parameter int TICKS_FROM_IDLE = 1,
    parameter int TICKS_FLUSH     = 3,
    parameter int TICKS_RESET     = 3,
    parameter int TICKS_CLKOFF    = 3,
    parameter int TICKS_RAMP      = 1000,
    parameter int TICKS_STAB      = 15000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       idle_req,
    input  logic       sleep_req,
    input  logic       wake_evt,
    output logic       cpu_clk_en,
    output logic       io_pwr_keep,
    output logic       flush_req,
    output logic       cpu_rst,
    output logic       clkgen_off,
    output logic       supply_ramp_en,
    output logic       boot_pulse,
    output logic [2:0] status
);
    localparam int MAXT = pms_max(pms_max(pms_max(TICKS_TO_IDLE, TICKS_FROM_IDLE),
                                          pms_max(TICKS_FLUSH, TICKS_RESET)),
                                  pms_max(pms_max(TICKS_CLKOFF, TICKS_RAMP), TICKS_STAB));
    localparam int CW = $clog2(MAXT + 1);

    pms_state_e    state, nxt;
    logic [CW-1:0] dur;
    logic          tmr_done, wake_pend, slp_pend, restart, arm_wake;

    assign restart  = (nxt != state);
    assign arm_wake = (state == ST_FLUSH) || (state == ST_RESET) || (state == ST_CLKOFF);

    pms_step_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
        .dur(dur), .done(tmr_done)
    );

    pms_event_latch u_wake_latch (
        .clk(clk), .rst_n(rst_n), .set(wake_evt && arm_wake),
        .clr(state == ST_SLEEP), .pend(wake_pend)
    );

    pms_event_latch u_sleep_latch (
        .clk(clk), .rst_n(rst_n), .set(sleep_req && (state == ST_IDLE)),
        .clr(state == ST_FLUSH), .pend(slp_pend)
    );

    always_comb begin
        unique case (state)
            ST_R2I:    dur = CW'(TICKS_TO_IDLE);
            ST_I2R:    dur = CW'(TICKS_FROM_IDLE);
            ST_FLUSH:  dur = CW'(TICKS_FLUSH);
            ST_RESET:  dur = CW'(TICKS_RESET);
            ST_CLKOFF: dur = CW'(TICKS_CLKOFF);
            ST_RAMP:   dur = CW'(TICKS_RAMP);
            ST_STAB:   dur = CW'(TICKS_STAB);
            default:   dur = CW'(1);
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (sleep_req || slp_pend) nxt = ST_FLUSH;
                else if (idle_req)         nxt = ST_R2I;
            end
            ST_R2I:    if (tmr_done) nxt = ST_IDLE;
            ST_IDLE:   if (wake_evt || sleep_req) nxt = ST_I2R;
            ST_I2R:    if (tmr_done) nxt = ST_RUN;
            ST_FLUSH:  if (tmr_done) nxt = ST_RESET;
            ST_RESET:  if (tmr_done) nxt = ST_CLKOFF;
            ST_CLKOFF: if (tmr_done) nxt = ST_SLEEP;
            ST_SLEEP:  if (wake_evt || wake_pend) nxt = ST_RAMP;
            ST_RAMP:   if (tmr_done) nxt = ST_STAB;
            ST_STAB:   if (tmr_done) nxt = ST_BOOT;
            ST_BOOT:   nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        cpu_clk_en     = 1'b0;
        io_pwr_keep    = 1'b1;
        flush_req      = 1'b0;
        cpu_rst        = 1'b0;
        clkgen_off     = 1'b0;
        supply_ramp_en = 1'b0;
        boot_pulse     = 1'b0;
        status         = {1'b1, MODE_RUN};
        unique case (state)
            ST_RUN:    begin cpu_clk_en = 1'b1; status = {1'b0, MODE_RUN}; end
            ST_R2I:    status = {1'b1, MODE_IDLE};
            ST_IDLE:   status = {1'b0, MODE_IDLE};
            ST_I2R:    status = {1'b1, MODE_RUN};
            ST_FLUSH:  begin cpu_clk_en = 1'b1; flush_req = 1'b1; status = {1'b1, MODE_SLEEP}; end
            ST_RESET:  begin cpu_clk_en = 1'b1; cpu_rst = 1'b1; status = {1'b1, MODE_SLEEP}; end
            ST_CLKOFF: begin cpu_rst = 1'b1; clkgen_off = 1'b1; status = {1'b1, MODE_SLEEP}; end
            ST_SLEEP:  begin
                cpu_rst = 1'b1; clkgen_off = 1'b1; io_pwr_keep = 1'b0;
                status = {1'b0, MODE_SLEEP};
            end
            ST_RAMP:   begin
                cpu_rst = 1'b1; clkgen_off = 1'b1; io_pwr_keep = 1'b0; supply_ramp_en = 1'b1;
            end
            ST_STAB:   cpu_rst = 1'b1;
            ST_BOOT:   begin cpu_clk_en = 1'b1; boot_pulse = 1'b1; end
            default:   status = {1'b0, MODE_RUN};
        endcase
    end

    // R4: flush is followed directly by the reset step
    p_entry_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_req) |-> (state == ST_RESET));
    // R5: in sleep only wakeup detection stays alive
    p_sleep_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == {1'b0, MODE_SLEEP}) |-> (!cpu_clk_en && clkgen_off && !supply_ramp_en));
    // R6: the boot strobe lasts one clock and lands in run
    p_boot_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_pulse |=> (!boot_pulse && cpu_clk_en && !cpu_rst));
    // R7: a latched wakeup is served on the first sleep clock
    p_wake_served_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake_pend) |=> (state == ST_RAMP));
    // R8: the sleep entry always starts from run
    p_entry_from_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> ($past(state) == ST_RUN));
    // R9: a sleep request in run wins over idle
    p_sleep_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req) |=> (state == ST_FLUSH));
endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_R2I = 2, T_I2R = 3, T_FLUSH = 2, T_RST = 3, T_CLKOFF = 4;
    localparam int T_RAMP = 5, T_STAB = 6;
    localparam int P_RUN = 0, P_R2I = 1, P_IDLE = 2, P_I2R = 3, P_FLUSH = 4, P_RST = 5;
    localparam int P_CLKOFF = 6, P_SLEEP = 7, P_RAMP = 8, P_STAB = 9, P_BOOT = 10;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic idle_req = 1'b0, sleep_req = 1'b0, wake_evt = 1'b0;
    logic cpu_clk_en, io_pwr_keep, flush_req, cpu_rst, clkgen_off, supply_ramp_en, boot_pulse;
    logic [2:0] status;

    pwr_mode_seq #(
        .TICKS_TO_IDLE(T_R2I), .TICKS_FROM_IDLE(T_I2R), .TICKS_FLUSH(T_FLUSH),
        .TICKS_RESET(T_RST), .TICKS_CLKOFF(T_CLKOFF), .TICKS_RAMP(T_RAMP), .TICKS_STAB(T_STAB)
    ) u_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .idle_req(idle_req), .sleep_req(sleep_req),
        .wake_evt(wake_evt), .cpu_clk_en(cpu_clk_en), .io_pwr_keep(io_pwr_keep),
        .flush_req(flush_req), .cpu_rst(cpu_rst), .clkgen_off(clkgen_off),
        .supply_ramp_en(supply_ramp_en), .boot_pulse(boot_pulse), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int tdiv = 1, tcnt = 0;
    int seq_p[32], seq_t[32], seq_c[32];
    int nseq = 0, last_p = -1;
    int exp_p[16], exp_t[16];
    int exp_n = 0;

    function automatic int classify();
        case (status)
            3'b000: return P_RUN;
            3'b101: return P_R2I;
            3'b001: return P_IDLE;
            3'b010: return P_SLEEP;
            3'b100: begin
                if (boot_pulse)     return P_BOOT;
                if (supply_ramp_en) return P_RAMP;
                if (cpu_rst)        return P_STAB;
                return P_I2R;
            end
            3'b110: begin
                if (flush_req)  return P_FLUSH;
                if (clkgen_off) return P_CLKOFF;
                return P_RST;
            end
            default: return -1;
        endcase
    endfunction

    // tick strobe, one clock in every tdiv
    initial forever begin
        @(negedge clk);
        tick = (tcnt == tdiv - 1);
        tcnt = (tcnt + 1) % tdiv;
    end

    // phase recorder: visits, ticks and clocks per visit
    initial forever begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            int p;
            int idx;
            p = classify();
            if (p != last_p) begin
                if (nseq < 32) nseq++;
                idx = nseq - 1;
                seq_p[idx] = p; seq_t[idx] = 0; seq_c[idx] = 0;
                last_p = p;
            end
            idx = nseq - 1;
            seq_c[idx]++;
            if (tick) seq_t[idx]++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_rec();
        nseq = 0; last_p = -1; exp_n = 0;
    endtask

    task automatic add_exp(input int p, input int t);
        exp_p[exp_n] = p; exp_t[exp_n] = t; exp_n++;
    endtask

    task automatic verify(input string req);
        check(nseq >= exp_n, {req, " visit count"}, nseq, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            check(seq_p[i] == exp_p[i], {req, " phase order"}, seq_p[i], exp_p[i]);
            if (exp_t[i] >= 0)
                check(seq_t[i] == exp_t[i], {req, " step ticks"}, seq_t[i], exp_t[i]);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) idle_req = 1'b1;
        if (which == 1) sleep_req = 1'b1;
        if (which == 2) wake_evt = 1'b1;
        if (which == 3) begin idle_req = 1'b1; sleep_req = 1'b1; end
        @(negedge clk);
        idle_req = 1'b0; sleep_req = 1'b0; wake_evt = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input int p);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #2;
            if (classify() == p) break;
        end
    endtask

    task automatic add_exit();
        add_exp(P_RAMP, T_RAMP); add_exp(P_STAB, T_STAB); add_exp(P_BOOT, -1); add_exp(P_RUN, -1);
    endtask

    task automatic run_all();
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R1 reset state
        check(status == 3'b000, "R1 status", status, 0);
        check(cpu_clk_en && io_pwr_keep, "R1 clk/io on", {cpu_clk_en, io_pwr_keep}, 3);
        check({flush_req, cpu_rst, clkgen_off, supply_ramp_en, boot_pulse} == 5'b0,
              "R1 others off", {flush_req, cpu_rst, clkgen_off, supply_ramp_en, boot_pulse}, 0);

        for (int d = 1; d <= 4; d++) begin
            tdiv = d; tcnt = 0;
            // R2 / R3 idle round trip
            clear_rec();
            pulse(0);
            wait_phase(P_IDLE);
            check(status == 3'b001 && !cpu_clk_en, "R10 idle status", status, 1);
            idle_cycles(3);
            pulse(2);
            wait_phase(P_RUN);
            add_exp(P_RUN, -1); add_exp(P_R2I, T_R2I); add_exp(P_IDLE, -1);
            add_exp(P_I2R, T_I2R); add_exp(P_RUN, -1);
            verify("R2 R3 idle round trip");

            // R4 / R5 / R6 full sleep cycle
            clear_rec();
            pulse(1);
            wait_phase(P_SLEEP);
            check(!cpu_clk_en && !io_pwr_keep && clkgen_off && !supply_ramp_en,
                  "R5 sleep outputs", {cpu_clk_en, io_pwr_keep, clkgen_off, supply_ramp_en}, 2);
            // R11 requests ignored in sleep
            pulse(3);
            idle_cycles(4);
            check(status == 3'b010, "R11 sleep holds", status, 2);
            pulse(2);
            wait_phase(P_RUN);
            add_exp(P_RUN, -1); add_exp(P_FLUSH, T_FLUSH); add_exp(P_RST, T_RST);
            add_exp(P_CLKOFF, T_CLKOFF); add_exp(P_SLEEP, -1); add_exit();
            verify("R4 R6 sleep cycle");
            check(seq_c[7] == 1, "R6 boot one clock", seq_c[7], 1);

            // R7 wakeup during entry
            clear_rec();
            pulse(1);
            wait_phase(P_RST);
            pulse(2);
            wait_phase(P_RUN);
            add_exp(P_RUN, -1); add_exp(P_FLUSH, T_FLUSH); add_exp(P_RST, T_RST);
            add_exp(P_CLKOFF, T_CLKOFF); add_exp(P_SLEEP, -1); add_exit();
            verify("R7 latched wake");
            check(seq_c[4] == 1, "R7 sleep one clock", seq_c[4], 1);

            // R8 sleep request from idle
            pulse(0);
            wait_phase(P_IDLE);
            idle_cycles(2);
            clear_rec();
            pulse(1);
            wait_phase(P_SLEEP);
            add_exp(P_IDLE, -1); add_exp(P_I2R, T_I2R); add_exp(P_RUN, -1);
            add_exp(P_FLUSH, T_FLUSH); add_exp(P_RST, T_RST); add_exp(P_CLKOFF, T_CLKOFF);
            add_exp(P_SLEEP, -1);
            verify("R8 idle to sleep");
            check(seq_c[2] == 1, "R8 run one clock", seq_c[2], 1);
            pulse(2);
            wait_phase(P_RUN);

            // R9 sleep wins over idle
            clear_rec();
            pulse(3);
            wait_phase(P_SLEEP);
            add_exp(P_RUN, -1); add_exp(P_FLUSH, T_FLUSH);
            verify("R9 priority");
            pulse(2);
            wait_phase(P_RUN);

            // R11 wakeup ignored in run
            clear_rec();
            pulse(2);
            idle_cycles(5);
            check(nseq == 1 && status == 3'b000, "R11 wake in run", status, 0);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired (all R) actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule